// File: doc/BRIEF.md
# Dual-Field Carry-Save Multiplier

This block multiplies two unsigned W-bit operands in either of two arithmetic fields, chosen per operation by a single mode input. With the mode input high it produces the ordinary integer product, as a prime-field datapath needs. With the mode input low it produces the carry-less product of two binary polynomials, as a binary-extension-field datapath needs. Both modes share one array of partial-product AND gates and one carry-save summing structure. The cells of that structure drop their carry outputs in polynomial mode, so each cell reduces to a three-input XOR.

The block is registered once. An operation presented with `in_valid` appears one clock later on three outputs. Two are the carry-save vectors, sum and carry, which a downstream multiply-accumulate stage can consume directly. The third is a resolved product, formed by a dual-mode final adder: a binary add in integer mode, and a bitwise XOR in polynomial mode. Modular reduction and accumulation belong to the surrounding logic.

Top module: `dual_field_tree_mult`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid`, `sum_vec`, `carry_vec` and `product` are all zero.
- R2: With `field_int` = 1 (integer mode), `product` equals the unsigned integer product `op_a * op_b`, 2W bits wide.
- R3: With `field_int` = 0 (polynomial mode), `carry_vec` is all zeros.
- R4: With `field_int` = 0, `sum_vec` equals the carry-less product, where bit k is the XOR over all i+j=k of `op_a[i] & op_b[j]`. Its top bit (2W-1) is therefore always zero.
- R5: A result appears on the outputs exactly one clock after the cycle in which `in_valid` is high, and `out_valid` is high in that cycle only.
- R6: After a cycle with `in_valid` low, `out_valid` is low and `sum_vec`, `carry_vec` and `product` keep their previous values.
- R7: With `field_int` = 1, (`sum_vec` + `carry_vec`) mod 2^(2W) equals `op_a * op_b`.
- R8: A zero operand gives all-zero outputs in both modes. All-ones operands give (2^W-1)^2 in integer mode, and the carry-less square of the all-ones polynomial in polynomial mode.
- R9: With `field_int` = 0, `product` equals `sum_vec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| field_int | input | 1 | 1: integer product, 0: carry-less polynomial product |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| sum_vec | output | 2W | Carry-save sum vector |
| carry_vec | output | 2W | Carry-save carry vector |
| product | output | 2W | Resolved product (add or XOR, by mode) |

## Verification
The assertions check on every cycle that polynomial-mode results never carry a nonzero carry vector or a set top bit. They also check that `out_valid` follows `in_valid` by exactly one cycle, and that idle cycles leave the result registers untouched. The correctness of the products themselves can only be shown by the bench's scenarios. The bench compares integer and carry-less products, and the carry-save sum, against reference values over random operands, zero operands, all-ones operands and single-bit operands. It runs these with back-to-back issue and with idle gaps between operations.

// File: rtl/dual_field_tree_mult.sv
module dual_field_tree_mult #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            field_int,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            out_valid,
  output logic [2*W-1:0]  sum_vec,
  output logic [2*W-1:0]  carry_vec,
  output logic [2*W-1:0]  product
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pp    [W];
  logic [PW-1:0] row_s [W];
  logic [PW-1:0] row_c [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pp
      assign pp[gi] = PW'({W{op_b[gi]}} & op_a) << gi;
    end
  endgenerate

  assign row_s[0] = pp[0];
  assign row_c[0] = '0;

  generate
    for (gi = 1; gi < W; gi++) begin : g_csa
      logic [PW-2:0] maj;
      assign row_s[gi] = row_s[gi-1] ^ row_c[gi-1] ^ pp[gi];
      assign maj = (row_s[gi-1][PW-2:0] & row_c[gi-1][PW-2:0])
                 | (row_s[gi-1][PW-2:0] & pp[gi][PW-2:0])
                 | (row_c[gi-1][PW-2:0] & pp[gi][PW-2:0]);
      assign row_c[gi] = {maj, 1'b0} & {PW{field_int}};
    end
  endgenerate

  logic field_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      field_q   <= 1'b0;
      sum_vec   <= '0;
      carry_vec <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        field_q   <= field_int;
        sum_vec   <= row_s[W-1];
        carry_vec <= row_c[W-1];
      end
    end
  end

  assign product = field_q ? (sum_vec + carry_vec) : (sum_vec ^ carry_vec);

  assert_poly_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !field_int) |=> (carry_vec == '0));

  assert_poly_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !field_int) |=> (sum_vec[PW-1] == 1'b0));

  assert_one_cycle_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> ($stable(sum_vec) && $stable(carry_vec) && !out_valid));

  assert_poly_resolve_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !field_int) |=> (product == sum_vec));
endmodule

// File: tb/dual_field_tree_mult_tb.sv
module dual_field_tree_mult_tb;
  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic field_int = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic out_valid;
  logic [PW-1:0] sum_vec, carry_vec, product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [PW-1:0] exp_q [$];
  logic          mode_q [$];

  always #2 clk = ~clk;

  dual_field_tree_mult #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .field_int(field_int),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .sum_vec(sum_vec), .carry_vec(carry_vec), .product(product)
  );

  function automatic logic [PW-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) r = r ^ (PW'(a) << i);
    return r;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    field_int = f;
    op_a = a;
    op_b = b;
    exp_q.push_back(f ? PW'(a) * PW'(b) : clmul(a, b));
    mode_q.push_back(f);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom();
      op_b = $urandom();
      field_int = $urandom();
    end
  endtask

  logic [PW-1:0] last_prod, last_sum, last_carry;
  bit have_last = 1'b0;

  initial begin : monitor
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected out_valid", PW'(1), PW'(0));
        end else begin
          logic [PW-1:0] e;
          logic m;
          e = exp_q.pop_front();
          m = mode_q.pop_front();
          if (m) begin
            check("R2 integer product", product, e);
            check("R7 carry-save sum", sum_vec + carry_vec, e);
          end else begin
            check("R4 carry-less sum_vec", sum_vec, e);
            check("R3 carry_vec zero", carry_vec, '0);
            check("R9 product equals sum_vec", product, sum_vec);
          end
        end
        last_prod = product; last_sum = sum_vec; last_carry = carry_vec;
        have_last = 1'b1;
      end else if (have_last) begin
        check("R6 product held", product, last_prod);
        check("R6 sum_vec held", sum_vec, last_sum);
        check("R6 carry_vec held", carry_vec, last_carry);
      end
    end
  end

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", PW'(out_valid), '0);
    check("R1 sum_vec in reset", sum_vec, '0);
    check("R1 carry_vec in reset", carry_vec, '0);
    check("R1 product in reset", product, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 out_valid after release", PW'(out_valid), '0);
    check("R1 product after release", product, '0);

    // R8 corners
    drive(1'b1, '0, 16'h1234);
    drive(1'b0, 16'hBEEF, '0);
    drive(1'b1, '1, '1);
    drive(1'b0, '1, '1);
    idle(1);
    drive(1'b1, 16'h8000, 16'h8000);
    drive(1'b0, 16'h8000, 16'h8000);
    drive(1'b1, 16'h0001, '1);
    drive(1'b0, '1, 16'h0001);
    idle(2);
    for (int k = 0; k < 200; k++) begin
      drive(k[0], W'($urandom()), W'($urandom()));
      if (k % 7 == 3) idle(1 + (k % 3));
    end
    idle(3);
    check("R5 all results delivered", PW'(exp_q.size()), '0);
    // R8 direct spot values of the reference
    check("R8 all-ones integer reference", PW'(16'hFFFF) * PW'(16'hFFFF), 32'hFFFE0001);
    check("R8 all-ones carry-less reference", clmul('1, '1), 32'h55555555);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule